// File: doc/BRIEF.md
# Addressed Three-Frame Serial Loader

This block receives display and control data over a three-wire serial link made of an enable line, a serial clock and a data line. Each transfer has two parts. While the enable is low, an 8-bit device address is clocked in, least significant bit first. The enable then goes high and a 48-bit payload follows. The last two payload bits name one of three frame layouts. Each layout carries one slice of a 105-bit segment image, and the first layout also carries a 7-bit control word.

All three serial inputs are resynchronised to the system clock. A bit is captured on each rising edge of the serial clock, so the clock may rest high or low between transfers. Received data reaches the output latches only when the enable falls, and only if three things hold: the address matched, exactly 48 payload bits arrived, and the frame code is one of the three defined layouts. A transfer that fails any of these leaves every output unchanged. A good transfer rewrites only its own slice of the image.

Top module: `lcd_serial_loader`

## Requirements
- R1: A transfer whose last 8 address bits before the enable rises do not form 0x46 (bits sent LSB first, i.e. 0,1,1,0,0,0,1,0) changes neither the image nor the control outputs.
- R2: Payload bits are taken on rising serial-clock edges while the enable is high. The first payload bit sent is payload position 0. In each frame, positions 0 upward map to the lowest image bit of that frame's slice upward.
- R3: A frame with code 00 (payload positions 46 and 47 both 0) writes positions 0..35 into image bits 0..35 and loads the control word.
- R4: A frame with code 01 (position 46 = 0, position 47 = 1) writes positions 0..35 into image bits 36..71. All other image bits and the control word stay unchanged.
- R5: A frame with code 10 (position 46 = 1, position 47 = 0) writes positions 0..32 into image bits 72..104. All other image bits and the control word stay unchanged.
- R6: A frame with code 11 changes no output.
- R7: A transfer with any payload length other than exactly 48 bits (47 or 49, for example) changes no output.
- R8: After reset the image is all zeros and the control word is all zeros: port code 0, third-level bias, segments shown, normal power mode.
- R9: Operation is the same whether the serial clock idles high or low between transfers.
- R10: Outputs do not change while the enable is still high. A valid transfer takes effect only after the enable falls.
- R11: The control word comes from a code-00 frame as follows. Positions 39..42 give port_code bits 3..0 (position 39 is the most significant bit). Position 43 gives half_bias, position 44 gives seg_blank and position 45 gives power_save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_en | input | 1 | Serial enable: low during the address, high during the payload |
| ser_clk | input | 1 | Serial bit clock; bits are taken on its rising edge |
| ser_dat | input | 1 | Serial data |
| seg_image | output | 105 | Latched segment image, bit 0 = first display bit |
| port_code | output | 4 | Count of low pins switched to general output |
| half_bias | output | 1 | 1 = half bias drive, 0 = third bias |
| seg_blank | output | 1 | 1 = force all segments off |
| power_save | output | 1 | 1 = power-saving mode |

## Verification
The assertions assume that the serial inputs are slow compared with `clk`. Each level of the serial clock and enable must last longer than the synchroniser depth plus one cycle. The enable must never change in the same synchronised cycle as a serial clock rising edge. Under these conditions the edge detector sees exactly one strobe per serial bit, and the enable edges fall cleanly between bits. The stimulus holds each serial clock phase for four system clocks and inserts a half-period gap on either side of every enable change. It drives both clock idle levels with the same payloads, so the bit counts the assertions rely on match what was sent.

// File: rtl/lcd_ld_pkg.sv
package lcd_ld_pkg;

    // Default geometry of the loader
    localparam int IMG_BITS_D   = 105;
    localparam int PAY_BITS_D   = 48;
    localparam int ADDR_BITS_D  = 8;
    localparam int SLICE_LO_D   = 36;
    localparam int SLICE_MID_D  = 36;
    localparam int CTRL_POS_D   = 39;
    localparam int CTRL_BITS    = 7;
    localparam logic [7:0] DEV_ID_D = 8'h46;

    typedef enum logic [1:0] {
        FRM_NONE = 2'd0,
        FRM_LOW  = 2'd1,
        FRM_MID  = 2'd2,
        FRM_HIGH = 2'd3
    } frame_e;

    typedef struct packed {
        logic [3:0] port_code;
        logic       half_bias;
        logic       blank;
        logic       save;
    } ctrl_t;

    // first = earlier-sent direction bit, second = final bit of the payload
    function automatic frame_e decode_dir(input logic first, input logic second);
        case ({first, second})
            2'b00:   return FRM_LOW;
            2'b01:   return FRM_MID;
            2'b10:   return FRM_HIGH;
            default: return FRM_NONE;
        endcase
    endfunction

    // bits[0] is the earliest-sent control bit
    function automatic ctrl_t unpack_ctrl(input logic [CTRL_BITS-1:0] bits);
        ctrl_t c;
        c.port_code = {bits[0], bits[1], bits[2], bits[3]};
        c.half_bias = bits[4];
        c.blank     = bits[5];
        c.save      = bits[6];
        return c;
    endfunction

endpackage

// File: rtl/lcd_ld_sync.sv
module lcd_ld_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain[0] <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/lcd_ld_front.sv
module lcd_ld_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_en,
    input  logic ser_clk,
    input  logic ser_dat,
    output logic en_lvl,
    output logic en_rise,
    output logic en_fall,
    output logic bit_stb,
    output logic bit_val
);
    logic [2:0] synced;
    logic       en_prev;
    logic       clk_prev;

    lcd_ld_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ser_en, ser_clk, ser_dat}),
        .dout (synced)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_prev  <= 1'b0;
            clk_prev <= 1'b0;
        end else begin
            en_prev  <= synced[2];
            clk_prev <= synced[1];
        end
    end

    assign en_lvl  = synced[2];
    assign en_rise = synced[2] & ~en_prev;
    assign en_fall = ~synced[2] & en_prev;
    assign bit_stb = synced[1] & ~clk_prev;
    assign bit_val = synced[0];
endmodule

// File: rtl/lcd_ld_addr.sv
module lcd_ld_addr #(
    parameter int                 ADDR_BITS = 8,
    parameter logic [ADDR_BITS-1:0] DEV_ID  = 8'h46
) (
    input  logic clk,
    input  logic rst,
    input  logic en_lvl,
    input  logic en_rise,
    input  logic bit_stb,
    input  logic bit_val,
    output logic addr_hit
);
    logic [ADDR_BITS-1:0] shreg;

    // LSB-first: newest bit enters at the top, earliest ends at bit 0
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            addr_hit <= 1'b0;
        end else begin
            if (bit_stb && !en_lvl)
                shreg <= {bit_val, shreg[ADDR_BITS-1:1]};
            if (en_rise)
                addr_hit <= (shreg == DEV_ID);
        end
    end

    AST_HIT_ONLY_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_hit) |-> $past(en_rise)); // R1

endmodule

// File: rtl/lcd_ld_payload.sv
module lcd_ld_payload #(
    parameter int PAY_BITS = 48
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en_lvl,
    input  logic                en_rise,
    input  logic                bit_stb,
    input  logic                bit_val,
    output logic [PAY_BITS-1:0] pay,
    output logic                pay_full
);
    localparam int CNT_W = $clog2(PAY_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PAY_BITS);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            pay <= '0;
        end else if (en_rise) begin
            cnt <= '0;
        end else if (en_lvl && bit_stb) begin
            for (int i = 0; i < PAY_BITS; i++) begin
                if (cnt == CNT_W'(i)) pay[i] <= bit_val;
            end
            // saturate one past full so over-length transfers are recognised
            if (cnt <= CNT_FULL) cnt <= cnt + 1'b1;
        end
    end

    assign pay_full = (cnt == CNT_FULL);

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        $past(en_rise) |-> (cnt == '0)); // R7

    AST_CNT_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(en_rise) && (cnt != $past(cnt))) |-> (cnt == $past(cnt) + 1'b1)); // R2

    AST_CNT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!$past(en_rise) && (cnt != $past(cnt))) |-> $past(bit_stb && en_lvl)); // R2

endmodule

// File: rtl/lcd_ld_store.sv
module lcd_ld_store
    import lcd_ld_pkg::*;
#(
    parameter int IMG_BITS  = 105,
    parameter int PAY_BITS  = 48,
    parameter int SLICE_LO  = 36,
    parameter int SLICE_MID = 36,
    parameter int CTRL_POS  = 39
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                commit,
    input  logic [PAY_BITS-1:0] pay,
    output logic [IMG_BITS-1:0] img,
    output ctrl_t               ctrl
);
    localparam int MID_BASE = SLICE_LO;
    localparam int HI_BASE  = SLICE_LO + SLICE_MID;
    localparam int SLICE_HI = IMG_BITS - HI_BASE;

    frame_e frm;
    assign frm = decode_dir(pay[PAY_BITS-2], pay[PAY_BITS-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            img  <= '0;
            ctrl <= '0;
        end else if (commit) begin
            case (frm)
                FRM_LOW: begin
                    img[SLICE_LO-1:0] <= pay[SLICE_LO-1:0];
                    ctrl              <= unpack_ctrl(pay[CTRL_POS +: CTRL_BITS]);
                end
                FRM_MID:  img[HI_BASE-1:MID_BASE] <= pay[SLICE_MID-1:0];
                FRM_HIGH: img[IMG_BITS-1:HI_BASE] <= pay[SLICE_HI-1:0];
                default: ;
            endcase
        end
    end

    AST_IMG_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !$stable(img) |-> $past(commit)); // R10

    AST_CTRL_ONLY_LOW_FRAME: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl) |-> $past(commit && frm == FRM_LOW)); // R3

    AST_MID_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (rst)
        $past(commit && frm == FRM_MID) |->
            ($stable(img[MID_BASE-1:0]) && $stable(img[IMG_BITS-1:HI_BASE]))); // R4

    AST_HIGH_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (rst)
        $past(commit && frm == FRM_HIGH) |->
            ($stable(img[HI_BASE-1:0]) && $stable(ctrl))); // R5

    AST_CODE11_IGNORED: assert property (@(posedge clk) disable iff (rst)
        $past(commit && frm == FRM_NONE) |-> ($stable(img) && $stable(ctrl))); // R6

endmodule

// File: rtl/lcd_serial_loader.sv
module lcd_serial_loader
    import lcd_ld_pkg::*;
#(
    parameter int IMG_BITS    = IMG_BITS_D,
    parameter int PAY_BITS    = PAY_BITS_D,
    parameter int ADDR_BITS   = ADDR_BITS_D,
    parameter logic [ADDR_BITS-1:0] DEV_ID = DEV_ID_D,
    parameter int SLICE_LO    = SLICE_LO_D,
    parameter int SLICE_MID   = SLICE_MID_D,
    parameter int CTRL_POS    = CTRL_POS_D,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ser_en,
    input  logic                ser_clk,
    input  logic                ser_dat,
    output logic [IMG_BITS-1:0] seg_image,
    output logic [3:0]          port_code,
    output logic                half_bias,
    output logic                seg_blank,
    output logic                power_save
);
    logic en_lvl, en_rise, en_fall, bit_stb, bit_val;
    logic addr_hit, pay_full, commit;
    logic [PAY_BITS-1:0] pay;
    ctrl_t ctrl;

    lcd_ld_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk     (clk),
        .rst     (rst),
        .ser_en  (ser_en),
        .ser_clk (ser_clk),
        .ser_dat (ser_dat),
        .en_lvl  (en_lvl),
        .en_rise (en_rise),
        .en_fall (en_fall),
        .bit_stb (bit_stb),
        .bit_val (bit_val)
    );

    lcd_ld_addr #(.ADDR_BITS(ADDR_BITS), .DEV_ID(DEV_ID)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .en_lvl   (en_lvl),
        .en_rise  (en_rise),
        .bit_stb  (bit_stb),
        .bit_val  (bit_val),
        .addr_hit (addr_hit)
    );

    lcd_ld_payload #(.PAY_BITS(PAY_BITS)) u_pay (
        .clk      (clk),
        .rst      (rst),
        .en_lvl   (en_lvl),
        .en_rise  (en_rise),
        .bit_stb  (bit_stb),
        .bit_val  (bit_val),
        .pay      (pay),
        .pay_full (pay_full)
    );

    assign commit = en_fall & addr_hit & pay_full;

    lcd_ld_store #(
        .IMG_BITS  (IMG_BITS),
        .PAY_BITS  (PAY_BITS),
        .SLICE_LO  (SLICE_LO),
        .SLICE_MID (SLICE_MID),
        .CTRL_POS  (CTRL_POS)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .pay    (pay),
        .img    (seg_image),
        .ctrl   (ctrl)
    );

    assign port_code  = ctrl.port_code;
    assign half_bias  = ctrl.half_bias;
    assign seg_blank  = ctrl.blank;
    assign power_save = ctrl.save;

    AST_BAD_ADDR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (en_fall && !addr_hit) |=> ($stable(seg_image) && $stable(ctrl))); // R1

    AST_LENGTH_GATES: assert property (@(posedge clk) disable iff (rst)
        (en_fall && !pay_full) |=> ($stable(seg_image) && $stable(ctrl))); // R7

    AST_HOLD_WHILE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (en_lvl && $past(en_lvl)) |-> ($stable(seg_image) && $stable(ctrl))); // R10

endmodule

// File: tb/lcd_serial_loader_test.sv
module lcd_serial_loader_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int WATCHDOG   = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_en = 1'b0;
    logic         ser_clk = 1'b0;
    logic         ser_dat = 1'b0;
    logic [104:0] seg_image;
    logic [3:0]   port_code;
    logic         half_bias, seg_blank, power_save;

    int total = 0;
    int bad   = 0;

    logic [104:0] exp_img  = '0;
    logic [6:0]   exp_ctrl = '0;  // {port_code, half_bias, seg_blank, power_save}

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_serial_loader uut (
        .clk        (clk),
        .rst        (rst),
        .ser_en     (ser_en),
        .ser_clk    (ser_clk),
        .ser_dat    (ser_dat),
        .seg_image  (seg_image),
        .port_code  (port_code),
        .half_bias  (half_bias),
        .seg_blank  (seg_blank),
        .power_save (power_save)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] ctrl_now();
        return {port_code, half_bias, seg_blank, power_save};
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input bit idle_hi);
        if (idle_hi) begin
            ser_clk = 1'b0;
            ser_dat = b;
            wait_cyc(HALF);
            ser_clk = 1'b1;
            wait_cyc(HALF);
        end else begin
            ser_dat = b;
            wait_cyc(HALF);
            ser_clk = 1'b1;
            wait_cyc(HALF);
            ser_clk = 1'b0;
        end
    endtask

    // payload: pl[i] is the i-th bit sent (R2 ordering)
    function automatic logic [47:0] mk_pay(input int fr, input int seed);
        logic [47:0] pl = '0;
        int w = (fr == 3) ? 33 : 36;
        logic [6:0] c;
        for (int i = 0; i < w; i++)
            pl[i] = (((i * (seed + 3)) + seed * 7) % 5) < 2;
        if (fr == 1) begin
            c = 7'((seed * 37 + 11) % 128);
            for (int k = 0; k < 7; k++) pl[39 + k] = c[k];
        end
        if (fr == 2) pl[47] = 1'b1;
        if (fr == 3) pl[46] = 1'b1;
        if (fr == 4) begin pl[46] = 1'b1; pl[47] = 1'b1; end
        return pl;
    endfunction

    task automatic model(input logic [47:0] pl);
        case ({pl[46], pl[47]})
            2'b00: begin
                exp_img[35:0] = pl[35:0];
                exp_ctrl = {pl[39], pl[40], pl[41], pl[42], pl[43], pl[44], pl[45]};
            end
            2'b01: exp_img[71:36]  = pl[35:0];
            2'b10: exp_img[104:72] = pl[32:0];
            default: ;
        endcase
    endtask

    task automatic xfer(input logic [7:0] a, input logic [47:0] pl, input int nbits,
                        input bit idle_hi, input string tag);
        ser_clk = idle_hi;
        ser_en  = 1'b0;
        wait_cyc(HALF);
        for (int i = 0; i < 8; i++) send_bit(a[i], idle_hi);
        wait_cyc(HALF);
        ser_en = 1'b1;
        wait_cyc(HALF);
        for (int i = 0; i < nbits; i++) send_bit((i < 48) ? pl[i] : 1'b0, idle_hi);
        wait_cyc(HALF);
        chk("R10 image before enable falls", 128'(seg_image), 128'(exp_img));
        ser_en = 1'b0;
        wait_cyc(10);
        if (a == 8'h46 && nbits == 48) model(pl);
        chk({tag, " image"}, 128'(seg_image), 128'(exp_img));
        chk({tag, " control"}, 128'(ctrl_now()), 128'(exp_ctrl));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(3);
        chk("R8 reset image", 128'(seg_image), 128'(0));
        chk("R8 reset control", 128'(ctrl_now()), 128'(0));

        // R3 R4 R5 R9 R11: every frame layout, several patterns, both idle levels
        for (int idle = 0; idle < 2; idle++)
            for (int seed = 0; seed < 3; seed++)
                for (int fr = 1; fr <= 3; fr++)
                    xfer(8'h46, mk_pay(fr, seed + 4 * idle), 48, bit'(idle),
                         (fr == 1) ? "R3 R11 R9" : (fr == 2) ? "R4 R9" : "R5 R9");

        // R6: code 11 ignored
        xfer(8'h46, mk_pay(4, 7), 48, 1'b0, "R6 idle low");
        xfer(8'h46, mk_pay(4, 8), 48, 1'b1, "R6 idle high");

        // R1: every single-bit corruption of the address
        for (int b = 0; b < 8; b++)
            xfer(8'h46 ^ (8'd1 << b), mk_pay((b % 3) + 1, 9 + b), 48, bit'(b % 2), "R1 wrong address");

        // R7: off-by-one lengths
        xfer(8'h46, mk_pay(1, 20), 47, 1'b0, "R7 short 47");
        xfer(8'h46, mk_pay(3, 21), 49, 1'b1, "R7 long 49");
        xfer(8'h46, mk_pay(2, 22), 47, 1'b1, "R7 short mid");

        // R2: recovery with a fresh valid frame after discarded ones
        xfer(8'h46, mk_pay(1, 23), 48, 1'b0, "R2 R3 recovery");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule